// File: doc/BRIEF.md
# Interrupt State, Enable and Test Register Bank

This block keeps the interrupt bookkeeping for a serial port with four interrupt sources. Each source has a sticky pending bit. A one-cycle pulse on the matching hardware event input sets the bit, and the bit stays set until software clears it. Software reaches the bank through a plain 32-bit register port with word addresses. The port exposes three registers:

- a pending register, cleared by writing ones to it;
- an enable mask, which can be read and written;
- a write-only force register, which ORs the written value into the pending bits so that firmware can raise any interrupt on purpose.

Each source drives its own interrupt line. A line is high while its pending bit and its enable bit are both set. The line is registered, so it follows the register state with a one-cycle lag. The logic that produces the event pulses sits outside this block.

Top module: `irq_reg_bank`

## Requirements
- R1: A synchronous active-high reset clears the pending bits, the enable bits, every interrupt line and the read data to zero.
- R2: The source bits are assigned as follows: bit 0 is transmit-watermark, bit 1 is receive-watermark, bit 2 is transmit-empty and bit 3 is receive-overflow. A pulse on `hw_event[i]` sets pending bit i in the next cycle, and interrupt line `irq_out[i]` belongs to source i.
- R3: A write to word address 0 (the pending register) clears every pending bit whose data bit is one and leaves unchanged every bit written as zero.
- R4: A write to word address 2 (the force register) ORs data bits [3:0] into the pending bits.
- R5: Word address 1 holds the enable mask. A write stores data bits [3:0], and a read returns them.
- R6: `irq_out[i]` is high exactly when pending bit i and enable bit i are both one. The line is registered and changes one cycle after either register changes.
- R7: If a hardware event and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: Read data appears on `bus_rdata` in the cycle after `bus_rd_en` is sampled high. The value is taken before any write in that same cycle. In cycles without a read, `bus_rdata` is zero.
- R9: A read of word address 2 returns zero.
- R10: Reads and writes at word addresses 3 and above leave the pending and enable bits unchanged, and such reads return zero.
- R11: Data bits above bit 3 are ignored on writes and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| hw_event | input | NUM_SRC (4) | One-cycle event pulses that set pending bits |
| irq_out | output | NUM_SRC (4) | Registered per-source interrupt lines |

## Verification
The results arrive with different latencies. A register write or an event pulse takes effect on the next clock edge. Read data is valid after one edge. An interrupt line moves one edge after the register that gates it, so a change caused by a stimulus appears on `irq_out` two edges later.

The bench drives inputs on the falling edge and samples on the following falling edge. It advances its reference model by exactly one edge per step. The model registers the interrupt lines from its own previous pending and enable values. It therefore checks the lagging line value right after a write, and the updated value one idle step later.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  // Word addresses of the mapped registers
  localparam int unsigned WADDR_PEND   = 0;
  localparam int unsigned WADDR_ENABLE = 1;
  localparam int unsigned WADDR_FORCE  = 2;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_PEND   = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_FORCE  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(WADDR_PEND);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(WADDR_ENABLE);
  localparam logic [ADDR_W-1:0] A_FORCE  = ADDR_W'(WADDR_FORCE);

  always_comb begin
    if (addr == A_PEND)        sel = SEL_PEND;
    else if (addr == A_ENABLE) sel = SEL_ENABLE;
    else if (addr == A_FORCE)  sel = SEL_FORCE;
    else                       sel = SEL_NONE;
  end

endmodule

// File: rtl/irq_src_cell.sv
// One interrupt source: sticky pending flop, enable flop, registered line.
module irq_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic sw_clr,
  input  logic sw_set,
  input  logic en_wr,
  input  logic en_wbit,
  output logic pend_q,
  output logic en_q,
  output logic irq_q
);

  logic pend_d;

  // Hardware set is ORed after the clear term, so it wins a collision
  always_comb begin
    pend_d = (pend_q & ~sw_clr) | sw_set | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (en_wr) en_q <= en_wbit;
      irq_q  <= pend_q & en_q;
    end
  end

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en,
  output logic [DATA_W-1:0]  rdata
);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_PEND:   rd_mux[NUM_SRC-1:0] = pend;
      SEL_ENABLE: rd_mux[NUM_SRC-1:0] = en;
      SEL_FORCE:  rd_mux = '0;
      SEL_NONE:   rd_mux = '0;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr_en,
  input  logic               bus_rd_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] hw_event,
  output logic [NUM_SRC-1:0] irq_out
);

  localparam int SPARE_W = DATA_W - NUM_SRC;

  reg_sel_e           sel;
  logic               wr_pend;
  logic               wr_enable;
  logic               wr_force;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] pend_vec;
  logic [NUM_SRC-1:0] en_vec;
  logic               wdata_unused;

  assign wbits        = bus_wdata[NUM_SRC-1:0];
  assign wdata_unused = ^bus_wdata[DATA_W-1:DATA_W-SPARE_W];

  irq_addr_decode #(.ADDR_W(ADDR_W)) i_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_pend   = bus_wr_en && (sel == SEL_PEND);
  assign wr_enable = bus_wr_en && (sel == SEL_ENABLE);
  assign wr_force  = bus_wr_en && (sel == SEL_FORCE);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_cell i_cell (
      .clk     (clk),
      .rst     (rst),
      .hw_set  (hw_event[g]),
      .sw_clr  (wr_pend & wbits[g]),
      .sw_set  (wr_force & wbits[g]),
      .en_wr   (wr_enable),
      .en_wbit (wbits[g]),
      .pend_q  (pend_vec[g]),
      .en_q    (en_vec[g]),
      .irq_q   (irq_out[g])
    );
  end

  irq_read_port #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) i_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_en (bus_rd_en),
    .sel   (sel),
    .pend  (pend_vec),
    .en    (en_vec),
    .rdata (bus_rdata)
  );

endmodule

// File: rtl/irq_reg_bank_chk.sv
module irq_reg_bank_chk
  import irq_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr_en,
  input logic               bus_rd_en,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_SRC-1:0] hw_event,
  input logic [NUM_SRC-1:0] irq_out,
  input logic [NUM_SRC-1:0] pend_vec,
  input logic [NUM_SRC-1:0] en_vec
);

  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(WADDR_PEND);
  localparam logic [ADDR_W-1:0] A_FORCE = ADDR_W'(WADDR_FORCE);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pend_vec == '0 && en_vec == '0 && irq_out == '0 && bus_rdata == '0));

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|hw_event) |=> ((pend_vec & $past(hw_event)) == $past(hw_event)));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == A_PEND && hw_event == '0)
      |=> ((pend_vec & $past(bus_wdata[NUM_SRC-1:0])) == '0));

  // R4
  force_or_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == A_FORCE)
      |=> ((pend_vec & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

  // R6
  irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == ($past(pend_vec) & $past(en_vec))));

  // R9
  force_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr == A_FORCE) |=> (bus_rdata == '0));

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr > A_FORCE) |=> (bus_rdata == '0));

  // R8
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> (bus_rdata == '0));

endmodule

bind irq_reg_bank irq_reg_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr_en (bus_wr_en),
  .bus_rd_en (bus_rd_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .hw_event  (hw_event),
  .irq_out   (irq_out),
  .pend_vec  (pend_vec),
  .en_vec    (en_vec)
);

// File: tb/test_irq_reg_bank.sv
module test_irq_reg_bank;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int NUM_SRC = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              bus_wr_en, bus_rd_en;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic [NUM_SRC-1:0] hw_event, irq_out;

  int n_chk = 0;
  int n_fail = 0;

  logic [NUM_SRC-1:0] pend_m, en_m, irq_m;
  logic [DATA_W-1:0]  rd_m;

  always #4 clk = ~clk;

  irq_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) i_irq_reg_bank (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_event(hw_event), .irq_out(irq_out)
  );

  function automatic logic [NUM_SRC-1:0] next_pend(
      logic [NUM_SRC-1:0] p, logic wr, logic [ADDR_W-1:0] a,
      logic [DATA_W-1:0] d, logic [NUM_SRC-1:0] ev);
    logic [NUM_SRC-1:0] clr, set;
    clr = (wr && a == 0) ? d[NUM_SRC-1:0] : '0;
    set = (wr && a == 2) ? d[NUM_SRC-1:0] : '0;
    return (p & ~clr) | set | ev;
  endfunction

  function automatic logic [DATA_W-1:0] read_val(
      logic rd, logic [ADDR_W-1:0] a, logic [NUM_SRC-1:0] p, logic [NUM_SRC-1:0] e);
    if (!rd)    return '0;
    if (a == 0) return DATA_W'(p);
    if (a == 1) return DATA_W'(e);
    return '0;
  endfunction

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock step: drive at a falling edge, sample at the next falling edge
  task automatic cyc(logic wr, logic rd, logic [ADDR_W-1:0] a,
                     logic [DATA_W-1:0] d, logic [NUM_SRC-1:0] ev);
    bus_wr_en = wr; bus_rd_en = rd; bus_addr = a; bus_wdata = d; hw_event = ev;
    @(negedge clk);
    rd_m   = read_val(rd, a, pend_m, en_m);
    irq_m  = pend_m & en_m;
    pend_m = next_pend(pend_m, wr, a, d, ev);
    if (wr && a == 1) en_m = d[NUM_SRC-1:0];
    check("R6 irq line", DATA_W'(irq_out), DATA_W'(irq_m));
    check("R8 read data", bus_rdata, rd_m);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, '0, '0, '0);
  endtask

  task automatic rd_reg(logic [ADDR_W-1:0] a, string tag, logic [DATA_W-1:0] exp);
    cyc(1'b0, 1'b1, a, '0, '0);
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr_en = 0; bus_rd_en = 0; bus_addr = '0; bus_wdata = '0; hw_event = '0;
    pend_m = '0; en_m = '0; irq_m = '0; rd_m = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports and in the registers
    check("R1 irq after reset", DATA_W'(irq_out), '0);
    check("R1 rdata after reset", bus_rdata, '0);
    rst = 1'b0;
    rd_reg(0, "R1 pending reset", '0);
    rd_reg(1, "R1 enable reset", '0);

    // R2 and R6: event on bit 0 with lines masked, then unmask
    cyc(0, 0, 0, '0, 4'b0001);
    idle();
    check("R6 masked line", DATA_W'(irq_out), '0);
    cyc(1, 0, 1, 32'h0000_000F, '0);
    check("R6 line lags enable write", DATA_W'(irq_out), '0);
    idle();
    check("R6 line after enable", DATA_W'(irq_out), 32'h1);

    // R5 and R11: enable write with upper bits set
    cyc(1, 0, 1, 32'hFFFF_FFF5, '0);
    rd_reg(1, "R5 R11 enable readback", 32'h5);
    cyc(1, 0, 1, 32'h0000_000F, '0);

    // R2: each remaining source bit
    cyc(0, 0, 0, '0, 4'b0010);
    cyc(0, 0, 0, '0, 4'b0100);
    cyc(0, 0, 0, '0, 4'b1000);
    rd_reg(0, "R2 all sources pending", 32'hF);
    idle();
    check("R2 all lines high", DATA_W'(irq_out), 32'hF);

    // R3: write-one-to-clear, zeros leave bits alone
    cyc(1, 0, 0, 32'h0000_0005, '0);
    rd_reg(0, "R3 clear bits 0 and 2", 32'hA);
    cyc(1, 0, 0, 32'h0000_0000, '0);
    rd_reg(0, "R3 zero write keeps bits", 32'hA);

    // R7: event and clear collide on bit 1
    cyc(1, 0, 0, 32'h0000_000F, 4'b0010);
    rd_reg(0, "R7 event wins over clear", 32'h2);

    // R4 and R11: force register ORs low bits only
    cyc(1, 0, 2, 32'hFFFF_FFF4, '0);
    rd_reg(0, "R4 R11 force ORs into pending", 32'h6);
    // R9
    rd_reg(2, "R9 force reads zero", '0);

    // R10: unmapped reads and writes
    rd_reg(3, "R10 unmapped read 3", '0);
    rd_reg(15, "R10 unmapped read 15", '0);
    cyc(1, 0, 5, 32'hFFFF_FFFF, '0);
    cyc(1, 0, 9, 32'h0000_0000, '0);
    rd_reg(0, "R10 pending untouched", 32'h6);
    rd_reg(1, "R10 enable untouched", 32'hF);

    // R8: no read means zero read data
    idle();
    check("R8 idle rdata", bus_rdata, '0);

    // Random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic wr, rd;
      logic [ADDR_W-1:0] a;
      logic [NUM_SRC-1:0] ev;
      wr = ($urandom % 3) == 0;
      rd = ($urandom % 2) == 0;
      a  = (($urandom % 4) == 0) ? ADDR_W'($urandom % 16) : ADDR_W'($urandom % 3);
      ev = (($urandom % 4) == 0) ? NUM_SRC'($urandom % 16) : '0;
      cyc(wr, rd, a, $urandom, ev);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule